// File: doc/BRIEF.md
# Receive Interrupt Policy Controller

This block decides when a serial receiver asks the CPU for attention. It watches the character arriving at the head of the receive FIFO, together with that character's error flags, and applies one of four interrupt policies selected by a 2-bit mode register. It drives a level interrupt request, a flag that steers the interrupt vector to the special-condition case, two latched error status bits, and a hold line. The hold line tells the FIFO to keep a faulty character in place and refuse further reads.

Software writes the mode through `mode_we`/`mode_in`. It clears error state with an error-reset strobe, re-arms the one-shot first-character policy with an arm strobe, and can reset the whole channel. Each CPU read of a character is reported on `char_read`. All state is registered. The interrupt request is a combinational function of that state.

The mode encodings are 00 off, 01 first character, 10 every character and 11 special only.

Top module: `rx_irq_policy`

## Requirements
- R1: While `rst_n` is low, or in the cycle after `cmd_chan_reset` is high, the mode becomes 00, the arm is cleared and every output is low.
- R2: A character counts when `char_valid` is high and `char_strip` is low. It is special when overrun, framing or end-of-frame is set, or when parity is set and `parity_special_en` is high. Overrun alone always makes it special.
- R3: In mode 00 `irq_req` stays low. A special character still sets `special_vec`.
- R4: In mode 01 the first counted character while armed raises `irq_req` and disarms the block. Writing mode 01, or pulsing `cmd_arm_next`, arms it. Writing any other mode disarms it. A special character requests an interrupt whether or not the block is armed.
- R5: In mode 10 every counted character raises `irq_req`. A special character also sets `special_vec` but never sets `fifo_hold`.
- R6: In mode 11 only special characters raise `irq_req`.
- R7: A character with `char_strip` high changes no output and no state.
- R8: In modes 01 and 11 a special character sets `fifo_hold`. `fifo_hold` and `special_vec` clear only on error reset, a write of mode 00, or reset.
- R9: `stat_overrun` latches any counted overrun and `stat_parity` latches any counted parity flag, in every mode. Both clear only on error reset or reset.
- R10: `irq_req` is high when the mode is not 00 and a character request or `special_vec` is pending. `char_read` clears the character request only while `fifo_hold` is low. A read never clears `special_vec`.
- R11: A character arriving in the same cycle as a clearing command is applied after that command. An arm command in the same cycle as a consuming character leaves the block armed.
- R12: Writing mode 00 clears the character request, `special_vec`, `fifo_hold` and the arm. It leaves the two status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_in | input | 2 | New mode value |
| char_valid | input | 1 | A new character is available |
| char_strip | input | 1 | The character is a sync character to be stripped |
| err_overrun | input | 1 | Receiver overrun on this character |
| err_framing | input | 1 | Framing error on this character |
| err_eof | input | 1 | End of frame on this character |
| err_parity | input | 1 | Parity error on this character |
| parity_special_en | input | 1 | Treat parity errors as special |
| char_read | input | 1 | CPU read of the head character |
| cmd_err_reset | input | 1 | Error reset command |
| cmd_arm_next | input | 1 | Re-arm the first-character policy |
| cmd_chan_reset | input | 1 | Channel reset command |
| irq_req | output | 1 | Receive interrupt request (level) |
| special_vec | output | 1 | Special condition pending, used for the vector |
| stat_overrun | output | 1 | Latched overrun status |
| stat_parity | output | 1 | Latched parity status |
| fifo_hold | output | 1 | Keep the head character and lock reads |

## Verification
Every input is sampled on one rising edge, and the registered state and all four registered outputs show the result right after that edge. `irq_req` follows in the same cycle, because it is combinational from that state. The bench drives inputs one time unit after a rising edge and keeps them for one full cycle. It advances a reference model from the same inputs and compares all five outputs one time unit after the next edge. Each result is therefore checked in the single cycle where it is due. Random runs mix every command and error flag in the same cycle, which exercises the ordering rules.

// File: rtl/rxi_pkg.sv
// Shared types for the receive interrupt policy controller.
// Assumes the mode encoding is software visible and therefore fixed.
package rxi_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        RXI_OFF     = 2'b00,
        RXI_FIRST   = 2'b01,
        RXI_ALL     = 2'b10,
        RXI_SPECIAL = 2'b11
    } rxi_mode_e;

    typedef struct packed {
        logic overrun;
        logic framing;
        logic eof;
        logic parity;
    } rxi_err_s;
endpackage

// File: rtl/rxi_cond_eval.sv
// Classifies the head character: whether it counts (not stripped) and
// whether it carries a special receive condition.
// Assumes flags are valid in the cycle char_valid is high.
module rxi_cond_eval
    import rxi_pkg::*;
(
    input  logic     char_valid,
    input  logic     char_strip,
    input  rxi_err_s err,
    input  logic     parity_special_en,
    output logic     new_char,
    output logic     new_special,
    output logic     new_ovr,
    output logic     new_par
);
    // Qualify the character and derive its special condition.
    always_comb begin
        new_char    = char_valid && !char_strip;
        new_ovr     = new_char && err.overrun;
        new_par     = new_char && err.parity;
        new_special = new_char && (err.overrun || err.framing || err.eof ||
                                   (err.parity && parity_special_en));
    end
endmodule

// File: rtl/rxi_mode_ctl.sv
// Holds the mode register and the one-shot arm of the first-character policy.
// Assumes at most one mode write per cycle; an arm command beats disarming.
module rxi_mode_ctl
    import rxi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_chan_reset,
    input  logic                mode_we,
    input  logic [MODE_W-1:0]   mode_in,
    input  logic                cmd_arm_next,
    input  logic                new_char,
    output rxi_mode_e           mode_q,
    output logic                armed_q,
    output logic                mode_off_wr,
    output logic                first_fire
);
    logic arm_set;

    // Decode mode-write side effects and the first-character trigger.
    always_comb begin
        mode_off_wr = mode_we && (rxi_mode_e'(mode_in) == RXI_OFF);
        arm_set     = cmd_arm_next || (mode_we && (rxi_mode_e'(mode_in) == RXI_FIRST));
        first_fire  = new_char && (mode_q == RXI_FIRST) && armed_q;
    end

    // Mode and arm registers.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_chan_reset) begin
            mode_q  <= RXI_OFF;
            armed_q <= 1'b0;
        end else begin
            if (mode_we)
                mode_q <= rxi_mode_e'(mode_in);
            if (arm_set)
                armed_q <= 1'b1;
            else if (mode_we || first_fire)
                armed_q <= 1'b0;
        end
    end

    // The arm is consumed by the first counted character.
    assert_arm_consumed_R4: assert property (@(posedge clk)
        disable iff (!rst_n || cmd_chan_reset)
        (mode_q == RXI_FIRST && armed_q && new_char && !cmd_arm_next && !mode_we)
        |=> !armed_q);
endmodule

// File: rtl/rxi_cond_latch.sv
// Keeps the special-condition flag, the FIFO hold and the error status bits.
// Assumes set events from the current character override same-cycle clears.
module rxi_cond_latch
    import rxi_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_chan_reset,
    input  rxi_mode_e mode_q,
    input  logic      mode_off_wr,
    input  logic      cmd_err_reset,
    input  logic      new_char,
    input  logic      new_special,
    input  logic      new_ovr,
    input  logic      new_par,
    output logic      spec_q,
    output logic      hold_q,
    output logic      stat_ovr_q,
    output logic      stat_par_q
);
    logic lock_mode;
    logic cond_clr;

    // Modes that freeze a faulty character, and the clear condition.
    always_comb begin
        lock_mode = (mode_q == RXI_FIRST) || (mode_q == RXI_SPECIAL);
        cond_clr  = cmd_err_reset || mode_off_wr;
    end

    // Special flag and hold: clear first, then the new character sets.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_chan_reset) begin
            spec_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            spec_q <= (spec_q && !cond_clr) || new_special;
            hold_q <= (hold_q && !cond_clr) || (new_special && lock_mode);
        end
    end

    // Latched status bits, cleared by error reset only.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_chan_reset) begin
            stat_ovr_q <= 1'b0;
            stat_par_q <= 1'b0;
        end else begin
            stat_ovr_q <= (stat_ovr_q && !cmd_err_reset) || new_ovr;
            stat_par_q <= (stat_par_q && !cmd_err_reset) || new_par;
        end
    end

    // Hold only starts in a locking mode.
    assert_hold_lock_mode_R8: assert property (@(posedge clk)
        disable iff (!rst_n || cmd_chan_reset)
        $rose(hold_q) |-> ($past(mode_q) == RXI_FIRST || $past(mode_q) == RXI_SPECIAL));

    // Error reset with no new character clears hold and special flag.
    assert_err_reset_clears_R8: assert property (@(posedge clk)
        disable iff (!rst_n || cmd_chan_reset)
        (cmd_err_reset && !new_char) |=> (!hold_q && !spec_q && !stat_ovr_q && !stat_par_q));

    // Overrun status persists until error reset.
    assert_ovr_latched_R9: assert property (@(posedge clk)
        disable iff (!rst_n || cmd_chan_reset)
        (stat_ovr_q && !cmd_err_reset) |=> stat_ovr_q);
endmodule

// File: rtl/rx_irq_policy.sv
// Receive interrupt policy controller top: combines character
// classification, mode/arm control and condition latching, and keeps the
// per-character interrupt request. Assumes one character event per cycle.
module rx_irq_policy
    import rxi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              char_valid,
    input  logic              char_strip,
    input  logic              err_overrun,
    input  logic              err_framing,
    input  logic              err_eof,
    input  logic              err_parity,
    input  logic              parity_special_en,
    input  logic              char_read,
    input  logic              cmd_err_reset,
    input  logic              cmd_arm_next,
    input  logic              cmd_chan_reset,
    output logic              irq_req,
    output logic              special_vec,
    output logic              stat_overrun,
    output logic              stat_parity,
    output logic              fifo_hold
);
    rxi_err_s  err;
    logic      new_char, new_special, new_ovr, new_par;
    rxi_mode_e mode_q;
    logic      armed_q, mode_off_wr, first_fire;
    logic      spec_q, hold_q, stat_ovr_q, stat_par_q;
    logic      char_pend_q;

    assign err = '{overrun: err_overrun, framing: err_framing,
                   eof: err_eof, parity: err_parity};

    rxi_cond_eval i_eval (
        .char_valid        (char_valid),
        .char_strip        (char_strip),
        .err               (err),
        .parity_special_en (parity_special_en),
        .new_char          (new_char),
        .new_special       (new_special),
        .new_ovr           (new_ovr),
        .new_par           (new_par)
    );

    rxi_mode_ctl i_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_chan_reset (cmd_chan_reset),
        .mode_we        (mode_we),
        .mode_in        (mode_in),
        .cmd_arm_next   (cmd_arm_next),
        .new_char       (new_char),
        .mode_q         (mode_q),
        .armed_q        (armed_q),
        .mode_off_wr    (mode_off_wr),
        .first_fire     (first_fire)
    );

    rxi_cond_latch i_latch (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_chan_reset (cmd_chan_reset),
        .mode_q         (mode_q),
        .mode_off_wr    (mode_off_wr),
        .cmd_err_reset  (cmd_err_reset),
        .new_char       (new_char),
        .new_special    (new_special),
        .new_ovr        (new_ovr),
        .new_par        (new_par),
        .spec_q         (spec_q),
        .hold_q         (hold_q),
        .stat_ovr_q     (stat_ovr_q),
        .stat_par_q     (stat_par_q)
    );

    // Per-character request: read (when unlocked) or mode-off clears, new character sets.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_chan_reset)
            char_pend_q <= 1'b0;
        else
            char_pend_q <= (char_pend_q && !((char_read && !hold_q) || mode_off_wr)) ||
                           (new_char && mode_q == RXI_ALL) || first_fire;
    end

    // Output drive.
    always_comb begin
        irq_req      = (mode_q != RXI_OFF) && (char_pend_q || spec_q);
        special_vec  = spec_q;
        stat_overrun = stat_ovr_q;
        stat_parity  = stat_par_q;
        fifo_hold    = hold_q;
    end

    // Every counted character requests an interrupt in the all-characters mode.
    assert_all_mode_irq_R5: assert property (@(posedge clk)
        disable iff (!rst_n || cmd_chan_reset)
        (mode_q == RXI_ALL && char_valid && !char_strip && !mode_we) |=> irq_req);

    // Stripped characters leave every output unchanged.
    assert_strip_ignored_R7: assert property (@(posedge clk)
        disable iff (!rst_n || cmd_chan_reset)
        (char_valid && char_strip && !char_read && !cmd_err_reset && !cmd_arm_next && !mode_we)
        |=> ($stable(irq_req) && $stable(fifo_hold) && $stable(special_vec) &&
             $stable(stat_overrun) && $stable(stat_parity)));

    // A read while the FIFO is held never drops a pending request.
    assert_locked_read_R10: assert property (@(posedge clk)
        disable iff (!rst_n || cmd_chan_reset)
        (hold_q && irq_req && !cmd_err_reset && !mode_we) |=> irq_req);
endmodule

// File: tb/test_rx_irq_policy.sv
`timescale 1ns/1ps
module test_rx_irq_policy;
    logic clk = 1'b0;
    logic rst_n, mode_we, char_valid, char_strip, err_overrun, err_framing;
    logic err_eof, err_parity, parity_special_en, char_read, cmd_err_reset;
    logic cmd_arm_next, cmd_chan_reset;
    logic [1:0] mode_in;
    logic irq_req, special_vec, stat_overrun, stat_parity, fifo_hold;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [1:0] m_mode;
    logic m_arm, m_cp, m_sp, m_hold, m_so, m_sq;

    always #5 clk = ~clk;

    rx_irq_policy i_rx_irq_policy (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
        .char_valid(char_valid), .char_strip(char_strip),
        .err_overrun(err_overrun), .err_framing(err_framing),
        .err_eof(err_eof), .err_parity(err_parity),
        .parity_special_en(parity_special_en), .char_read(char_read),
        .cmd_err_reset(cmd_err_reset), .cmd_arm_next(cmd_arm_next),
        .cmd_chan_reset(cmd_chan_reset), .irq_req(irq_req),
        .special_vec(special_vec), .stat_overrun(stat_overrun),
        .stat_parity(stat_parity), .fifo_hold(fifo_hold)
    );

    function automatic logic [4:0] expected();
        logic irq;
        irq = (m_mode != 2'b00) && (m_cp || m_sp);
        return {irq, m_sp, m_hold, m_so, m_sq};
    endfunction

    // Advance the model by one clock from the requirement rules.
    task automatic model_step();
        logic nc, sp, off_wr, fire, clr;
        nc     = char_valid && !char_strip;
        sp     = nc && (err_overrun || err_framing || err_eof || (err_parity && parity_special_en));
        off_wr = mode_we && mode_in == 2'b00;
        fire   = nc && m_mode == 2'b01 && m_arm;
        clr    = cmd_err_reset || off_wr;
        if (!rst_n || cmd_chan_reset) begin
            m_mode = 2'b00; m_arm = 0; m_cp = 0; m_sp = 0; m_hold = 0; m_so = 0; m_sq = 0;
        end else begin
            m_cp   = (m_cp && !((char_read && !m_hold) || off_wr)) || (nc && m_mode == 2'b10) || fire;
            m_hold = (m_hold && !clr) || (sp && (m_mode == 2'b01 || m_mode == 2'b11));
            m_sp   = (m_sp && !clr) || sp;
            m_so   = (m_so && !cmd_err_reset) || (nc && err_overrun);
            m_sq   = (m_sq && !cmd_err_reset) || (nc && err_parity);
            if (cmd_arm_next || (mode_we && mode_in == 2'b01)) m_arm = 1'b1;
            else if (mode_we || fire) m_arm = 1'b0;
            if (mode_we) m_mode = mode_in;
        end
    endtask

    task automatic idle();
        mode_we = 0; mode_in = 0; char_valid = 0; char_strip = 0;
        err_overrun = 0; err_framing = 0; err_eof = 0; err_parity = 0;
        char_read = 0; cmd_err_reset = 0; cmd_arm_next = 0; cmd_chan_reset = 0;
    endtask

    // One clock: update model, wait for the edge, compare, then idle the strobes.
    task automatic tick(input string tag);
        logic [4:0] got, exp;
        model_step();
        @(posedge clk);
        #1;
        exp = expected();
        got = {irq_req, special_vec, fifo_hold, stat_overrun, stat_parity};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: {irq,vec,hold,ovr,par} actual=%b expected=%b", tag, got, exp);
        end
        idle();
    endtask

    task automatic wr_mode(input logic [1:0] m, input string tag);
        mode_we = 1; mode_in = m; tick(tag);
    endtask

    task automatic chr(input logic o, input logic f, input logic e, input logic p, input string tag);
        char_valid = 1; err_overrun = o; err_framing = f; err_eof = e; err_parity = p; tick(tag);
    endtask

    initial begin
        idle();
        rst_n = 0; parity_special_en = 0;
        m_mode = 0; m_arm = 0; m_cp = 0; m_sp = 0; m_hold = 0; m_so = 0; m_sq = 0;
        @(posedge clk); #1;
        tick("R1 reset state");
        tick("R1 reset state");
        rst_n = 1;

        // Mode 00: no interrupt, special still flagged, status latched.
        chr(0, 1, 0, 0, "R3 framing in mode 00");
        chr(1, 0, 0, 0, "R3 overrun in mode 00");
        wr_mode(2'b00, "R12 mode 00 write keeps status");
        cmd_err_reset = 1; tick("R9 error reset clears status");

        // Mode 01: one-shot first character.
        wr_mode(2'b01, "R4 mode 01 arms");
        chr(0, 0, 0, 0, "R4 first char interrupts");
        char_read = 1; tick("R10 read clears request");
        chr(0, 0, 0, 0, "R4 second char ignored");
        cmd_arm_next = 1; tick("R4 re-arm");
        chr(0, 0, 0, 0, "R4 re-armed char interrupts");
        char_read = 1; tick("R10 read clears request");
        chr(0, 0, 1, 0, "R8 end of frame holds in mode 01");
        char_read = 1; tick("R10 read locked while held");
        cmd_err_reset = 1; tick("R8 error reset releases hold");

        // Mode 11: special only, parity enable.
        wr_mode(2'b11, "R6 enter mode 11");
        chr(0, 0, 0, 0, "R6 clean char no irq");
        chr(0, 0, 0, 1, "R2 parity not special when disabled");
        parity_special_en = 1;
        chr(0, 0, 0, 1, "R2 parity special when enabled");
        cmd_err_reset = 1; tick("R8 release");
        parity_special_en = 0;
        chr(1, 0, 0, 0, "R2 overrun always special");
        cmd_err_reset = 1; char_valid = 1; err_framing = 1; tick("R11 char after clear");
        cmd_err_reset = 1; tick("R8 release");

        // Mode 10: every character.
        wr_mode(2'b10, "R5 enter mode 10");
        chr(0, 0, 0, 0, "R5 clean char interrupts");
        char_read = 1; tick("R10 read clears");
        chr(1, 0, 0, 0, "R5 special flagged no hold");
        char_read = 1; tick("R10 read keeps special request");
        char_valid = 1; char_strip = 1; err_overrun = 1; err_parity = 1; tick("R7 stripped char ignored");
        cmd_err_reset = 1; tick("R9 error reset");
        char_valid = 1; char_strip = 1; tick("R7 stripped clean char ignored");

        // Same-cycle ordering in mode 01.
        wr_mode(2'b01, "R4 arm via mode write");
        char_valid = 1; cmd_arm_next = 1; tick("R11 arm beats consume");
        char_read = 1; tick("R10 read");
        chr(0, 0, 0, 0, "R11 still armed");
        chr(0, 1, 0, 0, "R4 special while disarmed");
        wr_mode(2'b00, "R12 mode 00 clears hold and vec");
        cmd_chan_reset = 1; tick("R1 channel reset");
        chr(1, 0, 0, 0, "R1 mode 00 after channel reset");

        // Constrained random mix.
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom;
            rst_n             = (r[3:0] != 0) || (i % 7 != 0);
            mode_we           = (r[7:4] == 0);
            mode_in           = r[9:8];
            char_valid        = r[10] | r[11];
            char_strip        = (r[14:12] == 0);
            err_overrun       = (r[17:15] == 0);
            err_framing       = (r[20:18] == 0);
            err_eof           = (r[23:21] == 0);
            err_parity        = (r[26:24] == 0);
            parity_special_en = r[27];
            char_read         = r[28];
            r = $urandom;
            cmd_err_reset     = (r[3:0] == 0);
            cmd_arm_next      = (r[7:4] == 0);
            cmd_chan_reset    = (r[15:8] == 0);
            tick("R11 random");
        end
        rst_n = 1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule